// File: doc/BRIEF.md
# Strap-Sampled Boost Configuration Controller

This block decides, each time the device enable line comes out of a qualified low period, how the signal-conditioning boost is configured. On release it copies the two strap inputs into its registers: a four-level AC boost selection with an "open" indication, and a three-level DC boost selection. A few cycles later it samples the two serial-bus pin levels. If both are high, it enters bus-programmable mode. If either is low, it stays in strap mode.

After that point, a two-wire target front end can read and write three small registers through a simple register port. The front end forwards each access with the target address it decoded. The block drives the chosen AC and DC boost codes, a configuration-active flag, a mode flag, and an enable for the link-monitoring state machine. That enable stays off while configuration is active.

A low pulse on the enable line shorter than a minimum number of clocks is treated as a glitch and ignored.

Top module: `cfg_strap_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it, `ac_boost` reads 3'b111, `dc_boost` reads 3'b101, `cfg_active` reads 1, and both `bus_mode` and `monitor_en` read 0.
- R2: On the first clock where `dev_enable` is high after a qualified low, the AC strap is latched into `ac_boost`:
  - levels 0, 1, 2 and 3 become 3'b000, 3'b001, 3'b011 and 3'b111;
  - `ac_strap_open`=1 forces 3'b111.
- R3: The DC strap is latched on the same clock as the AC strap. `dc_strap_sel` values 2'b00, 2'b01, 2'b10 and 2'b11 become 3'b011, 3'b101, 3'b111 and 3'b101.
- R4: SETTLE_CLKS clocks after the latch, `scl_lvl` and `sda_lvl` are sampled:
  - both high sets `bus_mode`=1 and keeps `cfg_active`=1;
  - otherwise `bus_mode`=0 and `cfg_active` clears on that same clock.
- R5: A low on `dev_enable` is qualified on its MIN_LOW_CLKS-th consecutive low clock. It then returns the block to the held state with `cfg_active`=1 and `bus_mode`=0. A low lasting at most MIN_LOW_CLKS-1 clocks changes nothing.
- R6: Strap inputs that change after the latch clock have no effect on `ac_boost` or `dc_boost` until the next qualified low and release.
- R7: A write takes effect only when all of the following hold:
  - the block is running;
  - `bus_mode` is 1;
  - `bus_addr` equals 7'h2C.

  Any other write changes nothing.
- R8: Register 0x01 holds the AC code in bits 6:4. A write of 3'b000, 3'b001, 3'b011 or 3'b111 is taken. Any other code is ignored. Other bits of the register read 0 and are not writable.
- R9: Register 0x0E holds the DC code in bits 2:0. A write of 3'b011, 3'b101 or 3'b111 is taken. Any other code is ignored. Bits 7:3 read 0.
- R10: Register 0x03 bit 0 is `cfg_active`, readable and writable in bus mode. `monitor_en` is 1 exactly when the block is running and `cfg_active` is 0.
- R11: Reads of any other offset return 8'h00, and writes to such offsets change nothing.
- R12: If a write arrives on the clock where a low is qualified, the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| dev_enable | input | 1 | Device enable line, low = hold in reset |
| ac_strap_lvl | input | 2 | Decoded AC boost strap level 0..3 |
| ac_strap_open | input | 1 | AC strap pin left open |
| dc_strap_sel | input | 2 | Decoded DC boost strap (00 low, 01 open/mid, 10 high) |
| scl_lvl | input | 1 | Sampled serial clock pin level |
| sda_lvl | input | 1 | Sampled serial data pin level |
| bus_addr | input | 7 | Target address of the current access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| ac_boost | output | 3 | Active AC boost code |
| dc_boost | output | 3 | Active DC boost code |
| cfg_active | output | 1 | Configuration-active flag |
| bus_mode | output | 1 | 1 = bus-programmable mode |
| monitor_en | output | 1 | Enable for the link-monitoring state machine |

## Verification
The two functions that can collide are low-pulse qualification on `dev_enable` and a register write. The bench holds `dev_enable` low for exactly MIN_LOW_CLKS-1 clocks and then asserts a write to the AC register together with the qualifying clock. It judges that the write is discarded, that `ac_boost` keeps its old code until the straps are re-latched, and that `bus_mode` drops on that same clock. A one-clock-shorter low followed by a write shows the opposite outcome: the write is taken and the mode is kept.

// File: rtl/cfgs_pkg.sv
// Package: shared types, register offsets and boost code helpers for the
// strap-sampled configuration controller. Assumes 8-bit offsets and data.
package cfgs_pkg;

    typedef enum logic [1:0] {
        ST_HELD   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2
    } seq_state_t;

    localparam logic [6:0] TGT_ADDR = 7'h2C;
    localparam logic [7:0] OFS_AC   = 8'h01;
    localparam logic [7:0] OFS_CTL  = 8'h03;
    localparam logic [7:0] OFS_DC   = 8'h0E;

    localparam logic [2:0] AC_MAX_CODE = 3'b111;
    localparam logic [2:0] DC_MID_CODE = 3'b101;

    // AC strap level to thermometer code
    function automatic logic [2:0] ac_level_code(input logic [1:0] lvl);
        logic [2:0] c;
        case (lvl)
            2'd0:    c = 3'b000;
            2'd1:    c = 3'b001;
            2'd2:    c = 3'b011;
            default: c = 3'b111;
        endcase
        return c;
    endfunction

    // DC strap selection to boost code; unused selection maps to mid
    function automatic logic [2:0] dc_sel_code(input logic [1:0] sel);
        logic [2:0] c;
        case (sel)
            2'd0:    c = 3'b011;
            2'd2:    c = 3'b111;
            default: c = DC_MID_CODE;
        endcase
        return c;
    endfunction

    function automatic logic ac_code_ok(input logic [2:0] c);
        return (c == 3'b000) || (c == 3'b001) || (c == 3'b011) || (c == 3'b111);
    endfunction

    function automatic logic dc_code_ok(input logic [2:0] c);
        return (c == 3'b011) || (c == 3'b101) || (c == 3'b111);
    endfunction

endpackage

// File: rtl/cfgs_reset_qual.sv
// Reset qualifier: counts consecutive low samples of the enable line and
// flags a valid low once MIN_LOW_CLKS of them have been seen (the flag is
// raised on the qualifying clock itself). Assumes dev_enable is already
// synchronous to clk.
module cfgs_reset_qual #(
    parameter int MIN_LOW_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dev_enable,
    output logic valid_low
);
    localparam int CW = $clog2(MIN_LOW_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_LOW_CLKS - 1);

    logic [CW-1:0] low_cnt;

    // count consecutive low samples, saturating at the qualify point
    always_ff @(posedge clk) begin
        if (!rst_n)               low_cnt <= '0;
        else if (dev_enable)      low_cnt <= '0;
        else if (low_cnt != LAST) low_cnt <= low_cnt + 1'b1;
    end

    assign valid_low = !dev_enable && (low_cnt == LAST);

    generate
        if (MIN_LOW_CLKS >= 2) begin : g_chk
            assert_short_low_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
                valid_low |-> $past(!dev_enable));
        end
    endgenerate

endmodule

// File: rtl/cfgs_mode_seq.sv
// Mode sequencer: holds the block while the enable line is qualified low.
// On release it pulses a strap latch, waits SETTLE_CLKS clocks, then picks
// bus or strap mode from the two bus pin levels. Assumes the pin levels
// are already synchronised.
module cfgs_mode_seq
    import cfgs_pkg::*;
#(
    parameter int SETTLE_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dev_enable,
    input  logic valid_low,
    input  logic scl_lvl,
    input  logic sda_lvl,
    output logic strap_latch,
    output logic decide,
    output logic bus_pick,
    output logic run,
    output logic bus_mode
);
    localparam int SW = $clog2(SETTLE_CLKS + 1);
    localparam logic [SW-1:0] SLAST = SW'(SETTLE_CLKS - 1);

    seq_state_t    state;
    logic [SW-1:0] set_cnt;

    assign strap_latch = (state == ST_HELD) && dev_enable;
    assign decide      = (state == ST_SETTLE) && (set_cnt == SLAST) && !valid_low;
    assign bus_pick    = scl_lvl && sda_lvl;
    assign run         = (state == ST_RUN);

    // sequence held -> settle -> run, any qualified low returns to held
    always_ff @(posedge clk) begin
        if (!rst_n || valid_low) begin
            state <= ST_HELD;
        end else begin
            case (state)
                ST_HELD:   if (dev_enable) state <= ST_SETTLE;
                ST_SETTLE: if (set_cnt == SLAST) state <= ST_RUN;
                default:   state <= ST_RUN;
            endcase
        end
    end

    // settle delay counter, cleared outside the settle state
    always_ff @(posedge clk) begin
        if (!rst_n || valid_low || state != ST_SETTLE) set_cnt <= '0;
        else if (set_cnt != SLAST)                      set_cnt <= set_cnt + 1'b1;
    end

    // mode flag decided once per release
    always_ff @(posedge clk) begin
        if (!rst_n || valid_low) bus_mode <= 1'b0;
        else if (decide)         bus_mode <= bus_pick;
    end

    assert_held_after_qual_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_low |=> (!run && !bus_mode));
    assert_run_after_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        decide |=> (run && (bus_mode == $past(bus_pick))));

endmodule

// File: rtl/cfgs_regfile.sv
// Register file: AC code (0x01 bits 6:4), control flag (0x03 bit 0) and
// DC code (0x0E bits 2:0). It latches the straps on release and accepts
// bus writes only while running in bus mode with a matching target
// address. Illegal codes and reserved bits are dropped.
module cfgs_regfile
    import cfgs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid_low,
    input  logic       strap_latch,
    input  logic       decide,
    input  logic       bus_pick,
    input  logic       run,
    input  logic       bus_mode,
    input  logic [1:0] ac_strap_lvl,
    input  logic       ac_strap_open,
    input  logic [1:0] dc_strap_sel,
    input  logic [6:0] bus_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [2:0] ac_q,
    output logic [2:0] dc_q,
    output logic       cfg_q
);
    logic       wr_fire;
    logic [2:0] ac_wcode;
    logic [2:0] dc_wcode;
    logic       wdata_unused;

    assign wr_fire      = reg_wr && run && bus_mode && (bus_addr == TGT_ADDR) && !valid_low;
    assign ac_wcode     = reg_wdata[6:4];
    assign dc_wcode     = reg_wdata[2:0];
    assign wdata_unused = reg_wdata[7] ^ reg_wdata[3];

    // AC boost code: strap on release, legal bus writes later
    always_ff @(posedge clk) begin
        if (!rst_n)
            ac_q <= AC_MAX_CODE;
        else if (strap_latch)
            ac_q <= ac_strap_open ? AC_MAX_CODE : ac_level_code(ac_strap_lvl);
        else if (wr_fire && reg_addr == OFS_AC && ac_code_ok(ac_wcode))
            ac_q <= ac_wcode;
    end

    // DC boost code: strap on release, legal bus writes later
    always_ff @(posedge clk) begin
        if (!rst_n)
            dc_q <= DC_MID_CODE;
        else if (strap_latch)
            dc_q <= dc_sel_code(dc_strap_sel);
        else if (wr_fire && reg_addr == OFS_DC && dc_code_ok(dc_wcode))
            dc_q <= dc_wcode;
    end

    // configuration-active flag: set on hold, resolved at mode pick, bus writable
    always_ff @(posedge clk) begin
        if (!rst_n || valid_low)                cfg_q <= 1'b1;
        else if (decide)                        cfg_q <= bus_pick;
        else if (wr_fire && reg_addr == OFS_CTL) cfg_q <= reg_wdata[0];
    end

    // read mux with reserved fields returning zero
    always_comb begin
        case (reg_addr)
            OFS_AC:  reg_rdata = {1'b0, ac_q, 4'b0000};
            OFS_CTL: reg_rdata = {7'b0, cfg_q};
            OFS_DC:  reg_rdata = {5'b0, dc_q};
            default: reg_rdata = 8'h00;
        endcase
    end

    assert_ac_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ac_code_ok(ac_q));
    assert_dc_code_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dc_code_ok(dc_q));
    assert_ac_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strap_latch && !reg_wr) |=> $stable(ac_q));

endmodule

// File: rtl/cfg_strap_ctrl.sv
// Top: strap-sampled boost configuration controller. It wires the reset
// qualifier, the mode sequencer and the register file, and gates the link
// monitor enable with the configuration flag. Assumes every input is
// synchronous to clk.
module cfg_strap_ctrl #(
    parameter int MIN_LOW_CLKS = 4,
    parameter int SETTLE_CLKS  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dev_enable,
    input  logic [1:0] ac_strap_lvl,
    input  logic       ac_strap_open,
    input  logic [1:0] dc_strap_sel,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic [6:0] bus_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [2:0] ac_boost,
    output logic [2:0] dc_boost,
    output logic       cfg_active,
    output logic       bus_mode,
    output logic       monitor_en
);
    logic valid_low, strap_latch, decide, bus_pick, run;

    cfgs_reset_qual #(.MIN_LOW_CLKS(MIN_LOW_CLKS)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_enable (dev_enable),
        .valid_low  (valid_low)
    );

    cfgs_mode_seq #(.SETTLE_CLKS(SETTLE_CLKS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_enable  (dev_enable),
        .valid_low   (valid_low),
        .scl_lvl     (scl_lvl),
        .sda_lvl     (sda_lvl),
        .strap_latch (strap_latch),
        .decide      (decide),
        .bus_pick    (bus_pick),
        .run         (run),
        .bus_mode    (bus_mode)
    );

    cfgs_regfile u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .valid_low     (valid_low),
        .strap_latch   (strap_latch),
        .decide        (decide),
        .bus_pick      (bus_pick),
        .run           (run),
        .bus_mode      (bus_mode),
        .ac_strap_lvl  (ac_strap_lvl),
        .ac_strap_open (ac_strap_open),
        .dc_strap_sel  (dc_strap_sel),
        .bus_addr      (bus_addr),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .ac_q          (ac_boost),
        .dc_q          (dc_boost),
        .cfg_q         (cfg_active)
    );

    assign monitor_en = run && !cfg_active;

    assert_strap_cfg_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run) && !bus_mode) |-> !cfg_active);
    assert_no_write_in_strap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bus_mode && !$rose(run)) |-> !cfg_active);

endmodule

// File: tb/cfg_strap_ctrl_bench.sv
module cfg_strap_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MINL = 4;
    localparam int SETL = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dev_enable = 1'b0;
    logic [1:0] ac_strap_lvl = 2'd2;
    logic       ac_strap_open = 1'b0;
    logic [1:0] dc_strap_sel = 2'd2;
    logic       scl_lvl = 1'b1, sda_lvl = 1'b1;
    logic [6:0] bus_addr = 7'h2C;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [2:0] ac_boost, dc_boost;
    logic       cfg_active, bus_mode, monitor_en;

    int vectors = 0;
    int fails = 0;
    bit cmp_on = 0;

    // behavioural reference state
    int m_state = 0;   // 0 held, 1 settle, 2 run
    int m_low = 0, m_set = 0;
    int m_ac = 7, m_dc = 5, m_cfg = 1, m_bus = 0;

    cfg_strap_ctrl #(.MIN_LOW_CLKS(MINL), .SETTLE_CLKS(SETL)) u_cfg_strap_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_enable(dev_enable),
        .ac_strap_lvl(ac_strap_lvl), .ac_strap_open(ac_strap_open),
        .dc_strap_sel(dc_strap_sel), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .bus_addr(bus_addr), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ac_boost(ac_boost),
        .dc_boost(dc_boost), .cfg_active(cfg_active), .bus_mode(bus_mode),
        .monitor_en(monitor_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ac_map(int lvl, bit open);
        int t[4] = '{0, 1, 3, 7};
        return open ? 7 : t[lvl];
    endfunction

    function automatic int dc_map(int sel);
        if (sel == 0) return 3;
        if (sel == 2) return 7;
        return 5;
    endfunction

    function automatic int model_read(int a);
        if (a == 8'h01) return m_ac * 16;
        if (a == 8'h03) return m_cfg;
        if (a == 8'h0E) return m_dc;
        return 0;
    endfunction

    // reference model advance
    always @(posedge clk) begin
        bit qual, wok;
        int code;
        if (!rst_n) begin
            m_state = 0; m_low = 0; m_set = 0;
            m_ac = 7; m_dc = 5; m_cfg = 1; m_bus = 0;
        end else begin
            qual = !dev_enable && (m_low >= MINL - 1);
            wok  = reg_wr && m_state == 2 && m_bus == 1 && bus_addr == 7'h2C && !qual;
            if (qual) begin
                m_state = 0; m_cfg = 1; m_bus = 0; m_set = 0;
            end else if (m_state == 0) begin
                if (dev_enable) begin
                    m_ac = ac_map(ac_strap_lvl, ac_strap_open);
                    m_dc = dc_map(dc_strap_sel);
                    m_state = 1; m_set = 0;
                end
            end else if (m_state == 1) begin
                if (m_set == SETL - 1) begin
                    m_bus = (scl_lvl && sda_lvl) ? 1 : 0;
                    m_cfg = m_bus; m_state = 2; m_set = 0;
                end else m_set++;
            end else if (wok) begin
                if (reg_addr == 8'h01) begin
                    code = reg_wdata[6:4];
                    if (code == 0 || code == 1 || code == 3 || code == 7) m_ac = code;
                end else if (reg_addr == 8'h03) m_cfg = reg_wdata[0];
                else if (reg_addr == 8'h0E) begin
                    code = reg_wdata[2:0];
                    if (code == 3 || code == 5 || code == 7) m_dc = code;
                end
            end
            if (dev_enable) m_low = 0;
            else if (m_low < MINL - 1) m_low++;
        end
    end

    task automatic chk(string req, int act, int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            vectors++;
            chk("R2 ac_boost", ac_boost, m_ac);
            chk("R3 dc_boost", dc_boost, m_dc);
            chk("R4 bus_mode", bus_mode, m_bus);
            chk("R10 cfg_active", cfg_active, m_cfg);
            chk("R10 monitor_en", monitor_en, (m_state == 2 && m_cfg == 0) ? 1 : 0);
            chk("R11 reg_rdata", reg_rdata, model_read(reg_addr));
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wr(int a, int d, int ta = 7'h2C);
        bus_addr = 7'(ta); reg_addr = 8'(a); reg_wdata = 8'(d); reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0; bus_addr = 7'h2C;
    endtask

    task automatic release_and_settle();
        dev_enable = 1'b1;
        cyc(SETL + 2);
    endtask

    task automatic qualified_low();
        dev_enable = 1'b0;
        cyc(MINL + 1);
    endtask

    initial begin
        cyc(3);
        cmp_on = 1;
        // R1 reset state
        chk("R1 ac", ac_boost, 7); chk("R1 dc", dc_boost, 5);
        chk("R1 cfg", cfg_active, 1); chk("R1 bus", bus_mode, 0); chk("R1 mon", monitor_en, 0);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 held after reset", monitor_en, 0);
        release_and_settle();
        chk("R2 level2 code", ac_boost, 3);
        chk("R3 high code", dc_boost, 7);
        chk("R4 bus mode picked", bus_mode, 1);
        chk("R4 cfg kept in bus mode", cfg_active, 1);
        // R6 strap change ignored
        ac_strap_lvl = 2'd0; dc_strap_sel = 2'd0; cyc(3);
        chk("R6 ac unchanged", ac_boost, 3);
        chk("R6 dc unchanged", dc_boost, 7);
        // R8 AC writes
        wr(8'h01, 8'hFF);
        chk("R8 ac legal write", ac_boost, 7);
        reg_addr = 8'h01; cyc();
        chk("R8 reserved bits read zero", reg_rdata, 8'h70);
        wr(8'h01, 8'h20);
        chk("R8 illegal ac ignored", ac_boost, 7);
        wr(8'h01, 8'h10);
        chk("R8 ac level1", ac_boost, 1);
        // R9 DC writes
        wr(8'h0E, 8'hF3);
        chk("R9 dc legal write", dc_boost, 3);
        wr(8'h0E, 8'h06);
        chk("R9 illegal dc ignored", dc_boost, 3);
        // R7 wrong address
        wr(8'h01, 8'h70, 7'h2D);
        chk("R7 wrong address ignored", ac_boost, 1);
        // R11 unmapped
        wr(8'h05, 8'hFF);
        reg_addr = 8'h05; cyc();
        chk("R11 unmapped reads zero", reg_rdata, 0);
        // R10 flag control
        wr(8'h03, 8'h00);
        chk("R10 cfg cleared", cfg_active, 0);
        chk("R10 monitor enabled", monitor_en, 1);
        wr(8'h03, 8'h01);
        chk("R10 monitor off when set", monitor_en, 0);
        wr(8'h03, 8'hFE);
        chk("R10 cfg cleared again", cfg_active, 0);
        // R5 glitch of MIN-1 clocks, then a write that must land
        dev_enable = 1'b0; cyc(MINL - 1); dev_enable = 1'b1;
        wr(8'h01, 8'h30);
        chk("R5 short low ignored", bus_mode, 1);
        chk("R5 write after glitch", ac_boost, 3);
        // R12 collision: write on the qualifying clock
        dev_enable = 1'b0; cyc(MINL - 1);
        wr(8'h01, 8'h00);
        chk("R12 write discarded", ac_boost, 3);
        chk("R12 mode dropped", bus_mode, 0);
        chk("R12 cfg set", cfg_active, 1);
        cyc(2);
        // strap mode release
        scl_lvl = 1'b0; ac_strap_lvl = 2'd1; dc_strap_sel = 2'd3;
        release_and_settle();
        chk("R2 level1 code", ac_boost, 1);
        chk("R3 unused sel mid", dc_boost, 5);
        chk("R4 strap mode", bus_mode, 0);
        chk("R4 cfg self cleared", cfg_active, 0);
        chk("R10 monitor in strap mode", monitor_en, 1);
        wr(8'h01, 8'h70);
        chk("R7 strap mode write ignored", ac_boost, 1);
        wr(8'h03, 8'h01);
        chk("R7 strap mode flag write ignored", cfg_active, 0);
        // open AC strap, only sda high
        qualified_low();
        chk("R5 qualified low held", monitor_en, 0);
        ac_strap_open = 1'b1; ac_strap_lvl = 2'd0; dc_strap_sel = 2'd1;
        scl_lvl = 1'b0; sda_lvl = 1'b1;
        release_and_settle();
        chk("R2 open strap max", ac_boost, 7);
        chk("R3 mid code", dc_boost, 5);
        chk("R4 one pin low strap mode", bus_mode, 0);
        qualified_low();
        ac_strap_open = 1'b0; ac_strap_lvl = 2'd3; dc_strap_sel = 2'd0;
        scl_lvl = 1'b1; sda_lvl = 1'b1;
        release_and_settle();
        chk("R2 level3 code", ac_boost, 7);
        chk("R3 low code", dc_boost, 3);
        wr(8'h01, 8'h00);
        chk("R8 ac level0", ac_boost, 0);
        cyc(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule